// File: doc/BRIEF.md
# Self-Test Error Log Register Block

This block sits beside a link self-test sequencer and records what goes wrong. Each time the sequencer reports a failed check, it raises a one-cycle error event that carries the failure class, the packet pattern, the packet length, the receive port, and the expected and observed values. The block counts every event in a saturating counter. It keeps a full record of the first sixteen events in a small log, which later events do not disturb.

Software reads the results over a simple word-addressed bus. The address space has a control region and six log regions. In the control region, offset 0 is the sticky tests-finished flag and offset 1 is the error total. Offset 2 is a trigger and holds no value: any access to it, read or write, restarts the run. A restart clears the flag, the total and the log position, and pulses `restart_o` for one cycle. Each log region is selected by the high address nibble and holds one record field; the low nibble selects the entry. Read data follows `addr_i` combinationally.

Top module: `selftest_errlog`

## Requirements
- R1: After reset the finished flag reads 0, the error total reads 0 and `restart_o` is low.
- R2: Address 0x00 reads 0 until `done_i` has been seen high. From then on it reads 1 in bit 0, even after `done_i` falls, until a restart.
- R3: Each cycle with `err_valid_i` high and no restart access raises the total at address 0x01 by one, with the new value visible the cycle after.
- R4: The total saturates at 2^CNT_W-1 and holds there under further events.
- R5: The n-th event since reset or restart (n from 0 to 15) is stored in entry n. Reading address {region, n} returns that entry's field, zero-extended. The regions are: 0x1 code, 0x2 packet type, 0x3 packet size, 0x4 receive port, 0x5 expected value, 0x6 seen value.
- R6: Events after the sixteenth are counted but leave every log entry unchanged.
- R7: An access with `req_i` high at address 0x02, with `we_i` at either value, raises `restart_o` for the following cycle. At the same edge it clears the finished flag, the total and the log position, so the next event is logged to entry 0.
- R8: An error event in the same cycle as a restart access is dropped: the total reads 0 afterwards.
- R9: Reads of addresses 0x02 through 0x0F, 0x70 through 0xFF, and entries at or above LOG_DEPTH return 0.
- R10: Writes to any address other than 0x02 change neither the flag, the total nor the log.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_valid_i | input | 1 | Error event strobe |
| err_code_i | input | CODE_W | Failure class |
| err_type_i | input | TYPE_W | Packet pattern in use |
| err_size_i | input | SIZE_W | Packet length in use |
| err_port_i | input | PORT_W | Receive port |
| err_exp_i | input | VAL_W | Expected value |
| err_seen_i | input | VAL_W | Observed value |
| done_i | input | 1 | Sequencer finished |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Bus access is a write |
| addr_i | input | 8 | Word address |
| wdata_i | input | DATA_W | Write data (no stored location) |
| rdata_o | output | DATA_W | Read data for `addr_i` |
| restart_o | output | 1 | One-cycle restart pulse |

## Verification
The bench builds the block with CNT_W set to 6. This makes the total saturate at 63, so the saturation boundary is reached within a few dozen events instead of 65535. LOG_DEPTH stays at 16, so every entry of all six log regions is read back and compared. Seventy events with arithmetically distinct fields drive the log past full and the counter past saturation. Restarts triggered by a read and by a write, one of them coinciding with an error event, exercise the clearing and priority rules.

// File: rtl/selftest_errlog_pkg.sv
package selftest_errlog_pkg;
  localparam int unsigned ADDR_W = 8;

  // high address nibble selects the region
  typedef enum logic [3:0] {
    RG_CTRL = 4'h0,
    RG_CODE = 4'h1,
    RG_TYPE = 4'h2,
    RG_SIZE = 4'h3,
    RG_PORT = 4'h4,
    RG_EXP  = 4'h5,
    RG_SEEN = 4'h6
  } region_e;

  localparam logic [3:0] OFS_DONE    = 4'h0;
  localparam logic [3:0] OFS_COUNT   = 4'h1;
  localparam logic [3:0] OFS_RESTART = 4'h2;

  localparam logic [ADDR_W-1:0] ADDR_RESTART = {RG_CTRL, OFS_RESTART};
endpackage

// File: rtl/stl_sat_counter.sv
module stl_sat_counter #(
  parameter int unsigned W   = 16,
  parameter logic [W-1:0] MAX = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         at_max_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (inc_i && cnt_q != MAX) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o    = cnt_q;
  assign at_max_o = (cnt_q == MAX);

  p_clr_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !clr_i && !at_max_o |=> cnt_o == $past(cnt_o) + W'(1));
  p_sat_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_max_o && !clr_i |=> at_max_o);
  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i && !clr_i |=> $stable(cnt_o));
endmodule

// File: rtl/stl_log_store.sv
module stl_log_store #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned CODE_W = 4,
  parameter int unsigned TYPE_W = 2,
  parameter int unsigned SIZE_W = 12,
  parameter int unsigned PORT_W = 2,
  parameter int unsigned VAL_W  = 32,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [VAL_W-1:0]  exp_i,
  input  logic [VAL_W-1:0]  seen_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [CODE_W-1:0] code_o,
  output logic [TYPE_W-1:0] type_o,
  output logic [SIZE_W-1:0] size_o,
  output logic [PORT_W-1:0] port_o,
  output logic [VAL_W-1:0]  exp_o,
  output logic [VAL_W-1:0]  seen_o
);
  localparam int unsigned ENT_W = CODE_W + TYPE_W + SIZE_W + PORT_W + 2*VAL_W;

  logic [ENT_W-1:0] ent_q [DEPTH];
  logic [ENT_W-1:0] wr_ent, rd_ent;

  assign wr_ent = {code_i, type_i, size_i, port_i, exp_i, seen_i};

  // storage has no reset: only entries below the write position are meaningful
  always_ff @(posedge clk_i) begin
    if (we_i) ent_q[wr_idx_i] <= wr_ent;
  end

  assign rd_ent = ent_q[rd_idx_i];
  assign {code_o, type_o, size_o, port_o, exp_o, seen_o} = rd_ent;

  p_wr_lands_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ent_q[$past(wr_idx_i)] == $past(wr_ent));
  p_idx_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> 32'(wr_idx_i) < DEPTH);
endmodule

// File: rtl/stl_reg_decode.sv
module stl_reg_decode
  import selftest_errlog_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned CODE_W = 4,
  parameter int unsigned TYPE_W = 2,
  parameter int unsigned SIZE_W = 12,
  parameter int unsigned PORT_W = 2,
  parameter int unsigned VAL_W  = 32,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              done_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [VAL_W-1:0]  exp_i,
  input  logic [VAL_W-1:0]  seen_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic              restart_sel_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [3:0] region, ofs;
  logic       ent_ok;

  assign region        = addr_i[7:4];
  assign ofs           = addr_i[3:0];
  assign rd_idx_o      = IDX_W'(ofs);
  assign ent_ok        = 32'(ofs) < DEPTH;
  assign restart_sel_o = (addr_i == ADDR_RESTART);

  always_comb begin
    rdata_o = '0;
    unique case (region)
      RG_CTRL: begin
        if (ofs == OFS_DONE)       rdata_o = DATA_W'(done_i);
        else if (ofs == OFS_COUNT) rdata_o = DATA_W'(count_i);
      end
      RG_CODE: if (ent_ok) rdata_o = DATA_W'(code_i);
      RG_TYPE: if (ent_ok) rdata_o = DATA_W'(type_i);
      RG_SIZE: if (ent_ok) rdata_o = DATA_W'(size_i);
      RG_PORT: if (ent_ok) rdata_o = DATA_W'(port_i);
      RG_EXP:  if (ent_ok) rdata_o = DATA_W'(exp_i);
      RG_SEEN: if (ent_ok) rdata_o = DATA_W'(seen_i);
      default: rdata_o = '0;
    endcase
  end

  always_comb begin
    if (region > 4'h6) p_unmapped_zero_r9: assert (rdata_o == '0);
  end
endmodule

// File: rtl/selftest_errlog.sv
module selftest_errlog
  import selftest_errlog_pkg::*;
#(
  parameter int unsigned LOG_DEPTH = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned CODE_W    = 4,
  parameter int unsigned TYPE_W    = 2,
  parameter int unsigned SIZE_W    = 12,
  parameter int unsigned PORT_W    = 2,
  parameter int unsigned VAL_W     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              err_valid_i,
  input  logic [CODE_W-1:0] err_code_i,
  input  logic [TYPE_W-1:0] err_type_i,
  input  logic [SIZE_W-1:0] err_size_i,
  input  logic [PORT_W-1:0] err_port_i,
  input  logic [VAL_W-1:0]  err_exp_i,
  input  logic [VAL_W-1:0]  err_seen_i,
  input  logic              done_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              restart_o
);
  localparam int unsigned IDX_W = (LOG_DEPTH > 1) ? $clog2(LOG_DEPTH) : 1;
  localparam int unsigned POS_W = $clog2(LOG_DEPTH + 1);

  logic               restart_sel, restart_hit, restart_q, done_q;
  logic [CNT_W-1:0]   err_cnt;
  logic               cnt_sat;
  logic [POS_W-1:0]   log_pos;
  logic               log_full, log_we;
  logic [IDX_W-1:0]   rd_idx;
  logic [CODE_W-1:0]  rd_code;
  logic [TYPE_W-1:0]  rd_type;
  logic [SIZE_W-1:0]  rd_size;
  logic [PORT_W-1:0]  rd_port;
  logic [VAL_W-1:0]   rd_exp, rd_seen;
  logic               unused_wr;

  // no writable storage: write data and direction have no effect
  assign unused_wr = ^{we_i, wdata_i};

  assign restart_hit = req_i && restart_sel;
  assign log_we      = err_valid_i && !restart_hit && !log_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q    <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      restart_q <= restart_hit;
      if (restart_hit) done_q <= 1'b0;
      else if (done_i) done_q <= 1'b1;
    end
  end

  assign restart_o = restart_q;

  stl_sat_counter #(.W(CNT_W), .MAX({CNT_W{1'b1}})) u_err_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (restart_hit),
    .inc_i    (err_valid_i),
    .cnt_o    (err_cnt),
    .at_max_o (cnt_sat)
  );

  stl_sat_counter #(.W(POS_W), .MAX(POS_W'(LOG_DEPTH))) u_log_pos (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (restart_hit),
    .inc_i    (err_valid_i),
    .cnt_o    (log_pos),
    .at_max_o (log_full)
  );

  stl_log_store #(
    .DEPTH(LOG_DEPTH), .CODE_W(CODE_W), .TYPE_W(TYPE_W),
    .SIZE_W(SIZE_W), .PORT_W(PORT_W), .VAL_W(VAL_W)
  ) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (log_we),
    .wr_idx_i (IDX_W'(log_pos)),
    .code_i   (err_code_i),
    .type_i   (err_type_i),
    .size_i   (err_size_i),
    .port_i   (err_port_i),
    .exp_i    (err_exp_i),
    .seen_i   (err_seen_i),
    .rd_idx_i (rd_idx),
    .code_o   (rd_code),
    .type_o   (rd_type),
    .size_o   (rd_size),
    .port_o   (rd_port),
    .exp_o    (rd_exp),
    .seen_o   (rd_seen)
  );

  stl_reg_decode #(
    .DEPTH(LOG_DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W), .CODE_W(CODE_W),
    .TYPE_W(TYPE_W), .SIZE_W(SIZE_W), .PORT_W(PORT_W), .VAL_W(VAL_W)
  ) u_decode (
    .addr_i        (addr_i),
    .done_i        (done_q),
    .count_i       (err_cnt),
    .code_i        (rd_code),
    .type_i        (rd_type),
    .size_i        (rd_size),
    .port_i        (rd_port),
    .exp_i         (rd_exp),
    .seen_i        (rd_seen),
    .rd_idx_o      (rd_idx),
    .restart_sel_o (restart_sel),
    .rdata_o       (rdata_o)
  );

  p_restart_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> $past(req_i) && $past(addr_i) == ADDR_RESTART);
  p_restart_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> !done_q && err_cnt == '0 && log_pos == '0);
  p_done_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && !restart_hit |=> done_q);
  p_log_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    log_full |-> !log_we);
  p_log_tracks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_sat && !log_full |-> 32'(err_cnt) == 32'(log_pos));
endmodule

// File: tb/selftest_errlog_tb.sv
module selftest_errlog_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 6;
  localparam int CNT_MAX    = (1 << CNT_W) - 1;
  localparam int DEPTH      = 16;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        err_valid_i = 0, done_i = 0, req_i = 0, we_i = 0;
  logic [3:0]  err_code_i = 0;
  logic [1:0]  err_type_i = 0, err_port_i = 0;
  logic [11:0] err_size_i = 0;
  logic [31:0] err_exp_i = 0, err_seen_i = 0, wdata_i = 0, rdata_o;
  logic [7:0]  addr_i = 0;
  logic        restart_o;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  selftest_errlog #(.LOG_DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .err_valid_i(err_valid_i),
    .err_code_i(err_code_i), .err_type_i(err_type_i), .err_size_i(err_size_i),
    .err_port_i(err_port_i), .err_exp_i(err_exp_i), .err_seen_i(err_seen_i),
    .done_i(done_i), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .restart_o(restart_o)
  );

  function automatic logic [31:0] f_code(int i); return 32'((i % 5) + 1); endfunction
  function automatic logic [31:0] f_type(int i); return 32'(i % 4); endfunction
  function automatic logic [31:0] f_size(int i); return 32'((60 + i*97) % 4096); endfunction
  function automatic logic [31:0] f_port(int i); return 32'((i + 1) % 4); endfunction
  function automatic logic [31:0] f_exp(int i);  return (32'h0101_0101 * 32'(i)) ^ 32'hA5A5_0F0F; endfunction
  function automatic logic [31:0] f_seen(int i); return f_exp(i) ^ (32'h1 << (i % 32)); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
    addr_i = a;
    #1;
    chk(req, rdata_o, exp, $sformatf("read @%h", a));
  endtask

  // one event, sampled after the edge that takes it
  task automatic ev(int i);
    @(negedge clk);
    err_valid_i = 1; err_code_i = 4'(f_code(i)); err_type_i = 2'(f_type(i));
    err_size_i = 12'(f_size(i)); err_port_i = 2'(f_port(i));
    err_exp_i = f_exp(i); err_seen_i = f_seen(i);
    @(negedge clk);
    err_valid_i = 0;
  endtask

  task automatic check_entry(int e, int i, string req);
    rd(8'h10 | 8'(e), f_code(i), req);
    rd(8'h20 | 8'(e), f_type(i), req);
    rd(8'h30 | 8'(e), f_size(i), req);
    rd(8'h40 | 8'(e), f_port(i), req);
    rd(8'h50 | 8'(e), f_exp(i),  req);
    rd(8'h60 | 8'(e), f_seen(i), req);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 0; we_i = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    rd(8'h00, 0, "R1");
    rd(8'h01, 0, "R1");
    chk("R1", 32'(restart_o), 0, "restart_o after reset");

    // R3 count per event, R5/R6 log fill past depth
    for (int i = 0; i < 20; i++) begin
      ev(i);
      rd(8'h01, 32'(i + 1), "R3");
    end
    for (int e = 0; e < DEPTH; e++) check_entry(e, e, (e < 4) ? "R5" : "R6");

    // R10 writes elsewhere are ignored
    wr(8'h01, 32'h0);
    wr(8'h00, 32'h1);
    wr(8'h15, 32'hF);
    wr(8'h55, 32'h0);
    rd(8'h01, 20, "R10");
    rd(8'h00, 0, "R10");
    rd(8'h15, f_code(5), "R10");
    rd(8'h55, f_exp(5), "R10");
    chk("R10", 32'(restart_o), 0, "no restart from other writes");

    // R9 unmapped and trigger location read as zero
    rd(8'h02, 0, "R9");
    rd(8'h03, 0, "R9");
    rd(8'h0F, 0, "R9");
    rd(8'h70, 0, "R9");
    rd(8'hA3, 0, "R9");
    rd(8'hFF, 0, "R9");

    // R2 sticky done
    rd(8'h00, 0, "R2");
    @(negedge clk); done_i = 1;
    @(negedge clk); done_i = 0;
    rd(8'h00, 1, "R2");
    repeat (3) @(negedge clk);
    rd(8'h00, 1, "R2");

    // R4 saturation
    n = 20;
    for (int i = 20; i < 70; i++) begin
      ev(i);
      n++;
      rd(8'h01, 32'((n > CNT_MAX) ? CNT_MAX : n), (n > CNT_MAX) ? "R4" : "R3");
    end
    for (int e = 0; e < DEPTH; e++) rd(8'h10 | 8'(e), f_code(e), "R6");
    rd(8'h6F, f_seen(15), "R6");

    // R7 restart by read access
    @(negedge clk);
    req_i = 1; we_i = 0; addr_i = 8'h02;
    @(negedge clk);
    req_i = 0;
    chk("R7", 32'(restart_o), 1, "restart pulse high");
    rd(8'h01, 0, "R7");
    rd(8'h00, 0, "R7");
    @(negedge clk);
    chk("R7", 32'(restart_o), 0, "restart pulse one cycle");
    ev(100);
    rd(8'h01, 1, "R7");
    check_entry(0, 100, "R7");
    ev(101);
    check_entry(1, 101, "R5");

    // R8 restart by write beats a simultaneous event
    @(negedge clk);
    req_i = 1; we_i = 1; addr_i = 8'h02; wdata_i = 32'h0;
    err_valid_i = 1; err_code_i = 4'h3;
    @(negedge clk);
    req_i = 0; we_i = 0; err_valid_i = 0;
    chk("R8", 32'(restart_o), 1, "restart pulse from write");
    rd(8'h01, 0, "R8");
    ev(200);
    check_entry(0, 200, "R8");
    rd(8'h01, 1, "R8");

    summary();
  end
endmodule